// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Cell with Saturating Add

This block is the multiplier cell of a reconfigurable compute array. Operands reach it from the array crossbar as 16-bit words, each with its own valid bit. A one-cycle configuration write picks the operation, the signedness of each operand, byte or word width, the use of a carry input, and a 16-bit constant. Each operand token then gives one registered result word with a valid bit.

The cell can run a multiply, a multiply by the configured constant, a multiply-accumulate, a plain accumulate, a saturating add (signed or unsigned, with an optional carry input), and a combined sum/difference. It can also pass operand A through, emit the constant, or stay idle. A 32-bit accumulator keeps the running total. It restarts on a configuration write or when a token arrives with the first-token flag set.

A three-state controller handles sequencing. **UNCONFIGURED** is the reset state, and the cell ignores tokens there. **CLEARED** means the accumulator is treated as zero. **ACCUMULATING** means the accumulator holds a running total. The transitions are:
- **LOAD**: a configuration write, from any state, goes to CLEARED.
- **START**: an accumulating token (multiply-accumulate or accumulate) in CLEARED goes to ACCUMULATING.
- **HOLD**: in every other case the state does not change.

Top module: `mac_cell`

## Requirements
- R1: After reset `res_vld` is 0. Until the first configuration write, the cell produces no result whatever the operand valids are.
- R2: A configuration write (`cfg_we`=1) takes effect from the next cycle. Tokens in the write cycle are dropped. The accumulator restarts from zero after every write.
- R3: Opcodes are 0 idle, 1 constant, 2 pass, 3 multiply, 4 constant-multiply, 5 multiply-accumulate, 6 accumulate, 7 saturating add, 8 sum/difference; 9 to 15 act as idle. Opcodes 3, 5, 7 and 8 fire when `a_vld` and `b_vld` are both 1. Opcodes 1, 2, 4 and 6 fire on `a_vld` alone. Idle never fires. A firing gives `res_vld`=1 with its result in the cycle after the sampling edge, and `res_vld` is 0 otherwise.
- R4: Multiply (3) returns the low 32 bits of the exact product of A and B. A is read as signed when `cfg_sgn_a`=1, and B is read as signed when `cfg_sgn_b`=1. All four combinations are supported.
- R5: Constant-multiply (4) returns A times the configured constant. The signedness of the constant is set by `cfg_sgn_b`.
- R6: Multiply-accumulate (5) adds the product (signedness as in R4) to the accumulator and outputs the new 32-bit total, wrapping modulo 2^32.
- R7: Accumulate (6) adds A, sign-extended when `cfg_sgn_a`=1 and zero-extended otherwise, to the accumulator and outputs the new total.
- R8: A token with `first`=1 makes the accumulating operation use zero in place of the held total. Later tokens continue from that new value.
- R9: Saturating add (7) with `cfg_sgn_a`=1 reads both operands as signed. A result above the most positive value gives that value, and a result below the most negative value gives that value.
- R10: Saturating add with `cfg_sgn_a`=0 reads both operands as unsigned. Overflow gives all ones. The result is placed in the low bits with zero above.
- R11: When `cfg_cin_en`=1, the saturating add also adds `c_in` before clamping. When `cfg_cin_en`=0, `c_in` is ignored.
- R12: Sum/difference (8) returns A-B, wrapped, in bits 31:16 and A+B, wrapped, in bits 15:0.
- R13: With `cfg_byte`=1, every operation uses bits 7:0 of A, B and the constant. Products and totals keep their exact 32-bit values. Saturation limits become 8-bit limits, with the result in bits 7:0. Sum and difference go in bits 7:0 and 23:16. All other result bits are 0.
- R14: Pass (2) returns A, and constant (1) returns the constant. Both are zero-extended, and bits 7:0 are used in byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 4 | Operation code (R3) |
| cfg_sgn_a | input | 1 | Operand A signed |
| cfg_sgn_b | input | 1 | Operand B / constant signed |
| cfg_byte | input | 1 | Byte-width mode |
| cfg_cin_en | input | 1 | Carry input enable for saturating add |
| cfg_const | input | 16 | Configured constant |
| a_data | input | 16 | Operand A |
| a_vld | input | 1 | Operand A valid |
| b_data | input | 16 | Operand B |
| b_vld | input | 1 | Operand B valid |
| c_in | input | 1 | Carry input |
| first | input | 1 | First-token flag, restarts accumulation |
| res_data | output | 32 | Result word |
| res_vld | output | 1 | Result valid |

## Verification
The assertions assume that configuration changes only through a `cfg_we` pulse, and that operand data is meaningful only in cycles where its valid bit is 1. The saturation properties also assume that `c_in` is a single carry bit. The bench drives every input only at the falling edge and holds it for a full cycle. It applies every configuration as its own one-cycle write, sometimes with tokens present, and it drives operand values only from the explicit extreme and ordinary value lists. In this way every property's antecedent is reached only with inputs inside these limits.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [3:0] {
        OP_IDLE    = 4'd0,
        OP_CONST   = 4'd1,
        OP_PASS    = 4'd2,
        OP_MULT    = 4'd3,
        OP_MULK    = 4'd4,
        OP_MACC    = 4'd5,
        OP_SUM     = 4'd6,
        OP_SATADD  = 4'd7,
        OP_SUMDIFF = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        S_UNCFG = 2'd0,
        S_CLEAR = 2'd1,
        S_ACCUM = 2'd2
    } cell_state_e;

    typedef struct packed {
        logic [3:0] op;
        logic       sgn_a;
        logic       sgn_b;
        logic       byte_mode;
        logic       cin_en;
    } cell_cfg_t;

    // operations that wait for both operands
    function automatic logic needs_pair(input logic [3:0] op);
        return (op == OP_MULT) || (op == OP_MACC) ||
               (op == OP_SATADD) || (op == OP_SUMDIFF);
    endfunction

    // operations triggered by operand A alone
    function automatic logic needs_single(input logic [3:0] op);
        return (op == OP_CONST) || (op == OP_PASS) ||
               (op == OP_MULK) || (op == OP_SUM);
    endfunction

    function automatic logic is_accumulating(input logic [3:0] op);
        return (op == OP_MACC) || (op == OP_SUM);
    endfunction

endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [DW-1:0]        x,
    input  logic                 is_signed,
    input  logic                 byte_mode,
    output logic signed [DW:0]   v
);

    localparam int PAD_B = DW + 1 - BW;

    always_comb begin
        if (byte_mode) begin
            if (is_signed) v = {{PAD_B{x[BW-1]}}, x[BW-1:0]};
            else           v = {{PAD_B{1'b0}},    x[BW-1:0]};
        end else begin
            v = {is_signed & x[DW-1], x};
        end
    end

endmodule

// File: rtl/mac_sat_add.sv
module mac_sat_add #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic signed [DW:0] va,
    input  logic signed [DW:0] vb,
    input  logic               cin,
    input  logic               is_signed,
    input  logic               byte_mode,
    output logic [DW-1:0]      y
);

    localparam int SW = DW + 2;

    localparam logic signed [SW-1:0] FULL_UMAX = {2'b00, {DW{1'b1}}};
    localparam logic signed [SW-1:0] FULL_SMAX = {3'b000, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] FULL_SMIN = ~FULL_SMAX;
    localparam logic signed [SW-1:0] BYTE_UMAX = {{(SW-BW){1'b0}}, {BW{1'b1}}};
    localparam logic signed [SW-1:0] BYTE_SMAX = {{(SW-BW+1){1'b0}}, {(BW-1){1'b1}}};
    localparam logic signed [SW-1:0] BYTE_SMIN = ~BYTE_SMAX;
    localparam logic [DW-1:0]        BYTE_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] hi;
    logic signed [SW-1:0] lo;
    logic signed [SW-1:0] clamped;

    always_comb begin
        sum = va + vb + $signed({{(SW-1){1'b0}}, cin});
        if (is_signed) begin
            hi = byte_mode ? BYTE_SMAX : FULL_SMAX;
            lo = byte_mode ? BYTE_SMIN : FULL_SMIN;
        end else begin
            hi = byte_mode ? BYTE_UMAX : FULL_UMAX;
            lo = '0;
        end
        if (sum > hi)      clamped = hi;
        else if (sum < lo) clamped = lo;
        else               clamped = sum;
        y = DW'(clamped) & (byte_mode ? BYTE_MASK : {DW{1'b1}});
    end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        acc_fire,
    output cell_state_e state,
    output logic        cfg_ok
);

    cell_state_e state_q;
    cell_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_UNCFG;
        else        state_q <= state_d;
    end

    // transitions: LOAD, START, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_UNCFG: if (cfg_we) state_d = S_CLEAR;
            S_CLEAR: begin
                if (cfg_we)        state_d = S_CLEAR;
                else if (acc_fire) state_d = S_ACCUM;
            end
            S_ACCUM: if (cfg_we) state_d = S_CLEAR;
            default: state_d = S_UNCFG;
        endcase
    end

    // outputs
    always_comb begin
        state  = state_q;
        cfg_ok = (state_q != S_UNCFG) && !cfg_we;
    end

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state_q == S_CLEAR)); // R2

    AST_ACCUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCUM && !cfg_we) |=> (state_q == S_ACCUM)); // R8

endmodule

// File: rtl/mac_cell.sv
module mac_cell
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [3:0]      cfg_op,
    input  logic            cfg_sgn_a,
    input  logic            cfg_sgn_b,
    input  logic            cfg_byte,
    input  logic            cfg_cin_en,
    input  logic [DW-1:0]   cfg_const,
    input  logic [DW-1:0]   a_data,
    input  logic            a_vld,
    input  logic [DW-1:0]   b_data,
    input  logic            b_vld,
    input  logic            c_in,
    input  logic            first,
    output logic [2*DW-1:0] res_data,
    output logic            res_vld
);

    localparam int AW = 2 * DW;
    localparam logic [DW-1:0] BYTE_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};

    cell_cfg_t       cfg_q;
    logic [DW-1:0]   konst_q;
    logic [AW-1:0]   acc_q;
    logic [AW-1:0]   res_q;
    logic            vld_q;

    cell_state_e     state;
    logic            cfg_ok;
    logic            tok_ok;
    logic            acc_fire;

    logic [DW-1:0]        src   [2];
    logic                 sgn   [2];
    logic signed [DW:0]   ext_v [2];

    logic signed [AW-1:0] prod;
    logic [AW-1:0]        addend;
    logic [AW-1:0]        acc_sum;
    logic [DW-1:0]        sat_y;
    logic [DW-1:0]        wmask;
    logic [DW-1:0]        sum_w;
    logic [DW-1:0]        diff_w;
    logic [AW-1:0]        res_d;

    // configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            konst_q <= '0;
        end else if (cfg_we) begin
            cfg_q   <= '{op: cfg_op, sgn_a: cfg_sgn_a, sgn_b: cfg_sgn_b,
                         byte_mode: cfg_byte, cin_en: cfg_cin_en};
            konst_q <= cfg_const;
        end
    end

    mac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .acc_fire (acc_fire),
        .state    (state),
        .cfg_ok   (cfg_ok)
    );

    // token acceptance
    always_comb begin
        tok_ok   = cfg_ok && a_vld &&
                   (needs_pair(cfg_q.op) ? b_vld : needs_single(cfg_q.op));
        acc_fire = tok_ok && is_accumulating(cfg_q.op);
    end

    // operand selection and extension
    always_comb begin
        src[0] = a_data;
        src[1] = (cfg_q.op == OP_MULK) ? konst_q : b_data;
        sgn[0] = cfg_q.sgn_a;
        sgn[1] = (cfg_q.op == OP_SATADD) ? cfg_q.sgn_a : cfg_q.sgn_b;
    end

    for (genvar i = 0; i < 2; i++) begin : g_ext
        mac_operand_ext #(.DW(DW), .BW(BW)) u_ext (
            .x         (src[i]),
            .is_signed (sgn[i]),
            .byte_mode (cfg_q.byte_mode),
            .v         (ext_v[i])
        );
    end

    mac_sat_add #(.DW(DW), .BW(BW)) u_sat (
        .va        (ext_v[0]),
        .vb        (ext_v[1]),
        .cin       (cfg_q.cin_en & c_in),
        .is_signed (cfg_q.sgn_a),
        .byte_mode (cfg_q.byte_mode),
        .y         (sat_y)
    );

    // arithmetic datapath
    always_comb begin
        prod    = AW'(ext_v[0]) * AW'(ext_v[1]);
        addend  = (cfg_q.op == OP_MACC) ? prod : AW'(ext_v[0]);
        acc_sum = ((state == S_CLEAR) || first ? '0 : acc_q) + addend;
        wmask   = cfg_q.byte_mode ? BYTE_MASK : {DW{1'b1}};
        sum_w   = (a_data + b_data) & wmask;
        diff_w  = (a_data - b_data) & wmask;
    end

    // result selection
    always_comb begin
        unique case (cfg_q.op)
            OP_CONST:          res_d = AW'(konst_q & wmask);
            OP_PASS:           res_d = AW'(a_data & wmask);
            OP_MULT, OP_MULK:  res_d = prod;
            OP_MACC, OP_SUM:   res_d = acc_sum;
            OP_SATADD:         res_d = AW'(sat_y);
            OP_SUMDIFF:        res_d = {diff_w, sum_w};
            default:           res_d = '0;
        endcase
    end

    // accumulator and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= tok_ok;
            if (tok_ok)        res_q <= res_d;
            if (cfg_we)        acc_q <= '0;
            else if (acc_fire) acc_q <= acc_sum;
        end
    end

    assign res_data = res_q;
    assign res_vld  = vld_q;

    AST_UNCFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UNCFG && !cfg_we) |=> !res_vld); // R1

    AST_CFG_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !res_vld); // R2

    AST_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        !a_vld |=> !res_vld); // R3

    AST_SSAT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_ok && cfg_q.op == OP_SATADD && cfg_q.sgn_a && !cfg_q.byte_mode &&
         !a_data[DW-1] && !b_data[DW-1]) |=> !res_data[DW-1]); // R9

    AST_USAT_GE: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_ok && cfg_q.op == OP_SATADD && !cfg_q.sgn_a && !cfg_q.byte_mode)
        |=> (res_data[DW-1:0] >= $past(a_data))); // R10

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_ok && cfg_q.op == OP_SATADD && cfg_q.byte_mode)
        |=> (res_data[AW-1:BW] == '0)); // R13

endmodule

// File: tb/tb_mac_cell.sv
module tb_mac_cell;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] K_IDLE = 4'd0, K_CONST = 4'd1, K_PASS = 4'd2,
                           K_MULT = 4'd3, K_MULK = 4'd4, K_MACC = 4'd5,
                           K_SUM = 4'd6, K_SAT = 4'd7, K_SD = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_op = '0;
    logic        cfg_sgn_a = 1'b0, cfg_sgn_b = 1'b0, cfg_byte = 1'b0, cfg_cin_en = 1'b0;
    logic [15:0] cfg_const = '0;
    logic [15:0] a_data = '0, b_data = '0;
    logic        a_vld = 1'b0, b_vld = 1'b0, c_in = 1'b0, first = 1'b0;
    logic [31:0] res_data;
    logic        res_vld;

    mac_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_sgn_a(cfg_sgn_a), .cfg_sgn_b(cfg_sgn_b), .cfg_byte(cfg_byte),
        .cfg_cin_en(cfg_cin_en), .cfg_const(cfg_const),
        .a_data(a_data), .a_vld(a_vld), .b_data(b_data), .b_vld(b_vld),
        .c_in(c_in), .first(first), .res_data(res_data), .res_vld(res_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string tag = "R1";

    bit          q_v [$];
    logic [31:0] q_d [$];
    string       q_t [$];

    // reference model state
    logic [3:0]  m_op = '0;
    bit          m_sa = 0, m_sb = 0, m_byte = 0, m_cen = 0, m_cfg = 0, m_clear = 1;
    logic [15:0] m_k = '0;
    longint      m_acc = 0;

    function automatic longint extv(logic [15:0] x, bit s, bit byt);
        if (byt) return s ? longint'($signed(x[7:0])) : longint'(x[7:0]);
        return s ? longint'($signed(x)) : longint'(x);
    endfunction

    task automatic push(bit v, logic [31:0] d);
        q_v.push_back(v);
        q_d.push_back(d);
        q_t.push_back(tag);
    endtask

    task automatic configure(logic [3:0] op, bit sa, bit sb, bit byt, bit cen,
                             logic [15:0] k, bit with_tok);
        @(negedge clk);
        cfg_we = 1; cfg_op = op; cfg_sgn_a = sa; cfg_sgn_b = sb;
        cfg_byte = byt; cfg_cin_en = cen; cfg_const = k;
        a_vld = with_tok; b_vld = with_tok; a_data = 16'h0005; b_data = 16'h0003;
        first = 0;
        push(1'b0, '0);
        m_op = op; m_sa = sa; m_sb = sb; m_byte = byt; m_cen = cen; m_k = k;
        m_cfg = 1; m_clear = 1; m_acc = 0;
    endtask

    task automatic step(bit av, logic [15:0] a, bit bv, logic [15:0] b, bit ci, bit fst);
        bit     fire, pair, single;
        longint ea, eb, s, hi, lo, mask, base, r;
        int     w;
        @(negedge clk);
        cfg_we = 0; a_vld = av; a_data = a; b_vld = bv; b_data = b; c_in = ci; first = fst;
        w    = m_byte ? 8 : 16;
        mask = (64'd1 << w) - 1;
        pair   = (m_op == K_MULT) || (m_op == K_MACC) || (m_op == K_SAT) || (m_op == K_SD);
        single = (m_op == K_CONST) || (m_op == K_PASS) || (m_op == K_MULK) || (m_op == K_SUM);
        fire = m_cfg && av && (pair ? bv : single);
        r = 0;
        if (fire) begin
            case (m_op)
                K_CONST: r = longint'(m_k) & mask;
                K_PASS:  r = longint'(a) & mask;
                K_MULT:  r = extv(a, m_sa, m_byte) * extv(b, m_sb, m_byte);
                K_MULK:  r = extv(a, m_sa, m_byte) * extv(m_k, m_sb, m_byte);
                K_MACC, K_SUM: begin
                    base = (m_clear || fst) ? 0 : m_acc;
                    if (m_op == K_MACC) r = base + extv(a, m_sa, m_byte) * extv(b, m_sb, m_byte);
                    else                r = base + extv(a, m_sa, m_byte);
                    m_acc = r & 64'hFFFF_FFFF;
                    m_clear = 0;
                end
                K_SAT: begin
                    ea = extv(a, m_sa, m_byte);
                    eb = extv(b, m_sa, m_byte);
                    s  = ea + eb + ((m_cen && ci) ? 1 : 0);
                    hi = m_sa ? ((64'd1 << (w-1)) - 1) : mask;
                    lo = m_sa ? -(64'd1 << (w-1)) : 0;
                    if (s > hi) s = hi;
                    if (s < lo) s = lo;
                    r = s & mask;
                end
                K_SD: r = ((((longint'(a) - longint'(b)) & mask)) << 16) |
                          ((longint'(a) + longint'(b)) & mask);
                default: r = 0;
            endcase
        end
        push(fire, 32'(r));
    endtask

    // monitor / scoreboard
    initial begin : monitor
        bit          v;
        logic [31:0] d;
        string       t;
        forever begin
            @(posedge clk);
            #1;
            if (q_v.size() > 0) begin
                v = q_v.pop_front();
                d = q_d.pop_front();
                t = q_t.pop_front();
                checks++;
                if (res_vld !== v || (v && res_data !== d)) begin
                    errors++;
                    $display("FAIL %s: got vld=%0b data=%h expected vld=%0b data=%h",
                             t, res_vld, res_data, v, d);
                end
            end
        end
    end

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h1234, 16'hAB80, 16'h007F};

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (res_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: got vld=%0b expected vld=0", res_vld);
        end
        rst_n = 1;
        tag = "R1";
        step(1, 16'h0003, 1, 16'h0004, 0, 0);
        step(1, 16'hFFFF, 1, 16'hFFFF, 1, 1);

        // R4 / R13: multiply, all signedness combinations, word and byte
        for (int byt = 0; byt < 2; byt++) begin
            for (int sa = 0; sa < 2; sa++) begin
                for (int sb = 0; sb < 2; sb++) begin
                    tag = byt ? "R13" : "R4";
                    configure(K_MULT, sa[0], sb[0], byt[0], 0, 16'h0000, 0);
                    foreach (vals[i]) foreach (vals[j]) step(1, vals[i], 1, vals[j], 0, 0);
                end
            end
        end

        // R5: constant multiply
        tag = "R5";
        for (int sb = 0; sb < 2; sb++) begin
            configure(K_MULK, 1, sb[0], 0, 0, 16'h8000, 0);
            foreach (vals[i]) step(1, vals[i], 0, 16'h0000, 0, 0);
            configure(K_MULK, 0, sb[0], 1, 0, 16'h12FF, 0);
            foreach (vals[i]) step(1, vals[i], 0, 16'h0000, 0, 0);
        end

        // R3: pair operation waits for B; idle never fires
        tag = "R3";
        configure(K_MULT, 0, 0, 0, 0, 16'h0000, 0);
        step(1, 16'h0002, 0, 16'h0003, 0, 0);
        step(0, 16'h0002, 1, 16'h0003, 0, 0);
        configure(K_IDLE, 0, 0, 0, 0, 16'h0000, 0);
        step(1, 16'h0002, 1, 16'h0003, 0, 0);
        configure(4'd12, 0, 0, 0, 0, 16'h0000, 0);
        step(1, 16'h0002, 1, 16'h0003, 0, 0);

        // R6 / R8: multiply-accumulate with restart
        tag = "R6";
        configure(K_MACC, 1, 1, 0, 0, 16'h0000, 0);
        step(1, 16'h8000, 1, 16'h8000, 0, 0);
        step(1, 16'h8000, 1, 16'h8000, 0, 0);
        step(1, 16'h7FFF, 1, 16'hFFFF, 0, 0);
        step(1, 16'h0003, 0, 16'h0004, 0, 0);
        step(1, 16'hFFFF, 1, 16'h0002, 0, 0);
        tag = "R8";
        step(1, 16'h0003, 1, 16'h0004, 0, 1);
        step(1, 16'h0005, 1, 16'h0006, 0, 0);
        tag = "R6";
        configure(K_MACC, 0, 1, 0, 0, 16'h0000, 0);
        step(1, 16'hFFFF, 1, 16'h8000, 0, 0);
        step(1, 16'hFFFF, 1, 16'h7FFF, 0, 0);

        // R2: config write with tokens present, accumulator restarts
        tag = "R2";
        configure(K_SUM, 1, 0, 0, 0, 16'h0000, 1);
        step(1, 16'h0010, 0, 16'h0000, 0, 0);
        configure(K_SUM, 1, 0, 0, 0, 16'h0000, 1);
        step(1, 16'h0001, 0, 16'h0000, 0, 0);

        // R7: accumulate, signed and unsigned
        tag = "R7";
        configure(K_SUM, 1, 0, 0, 0, 16'h0000, 0);
        foreach (vals[i]) step(1, vals[i], 0, 16'h0000, 0, 0);
        configure(K_SUM, 0, 0, 0, 0, 16'h0000, 0);
        foreach (vals[i]) step(1, vals[i], 0, 16'h0000, 0, 0);
        tag = "R8";
        step(1, 16'h0009, 0, 16'h0000, 0, 1);
        step(1, 16'h0001, 0, 16'h0000, 0, 0);

        // R9 / R10 / R11 / R13: saturating add
        for (int byt = 0; byt < 2; byt++) begin
            for (int sa = 0; sa < 2; sa++) begin
                for (int cen = 0; cen < 2; cen++) begin
                    tag = cen ? "R11" : (byt ? "R13" : (sa ? "R9" : "R10"));
                    configure(K_SAT, sa[0], 0, byt[0], cen[0], 16'h0000, 0);
                    foreach (vals[i]) foreach (vals[j]) step(1, vals[i], 1, vals[j], 1, 0);
                    step(1, 16'h7FFE, 1, 16'h0000, 1, 0);
                    step(1, 16'hFFFE, 1, 16'h0000, 1, 0);
                    step(1, 16'h007E, 1, 16'h0000, 0, 0);
                end
            end
        end

        // R12 / R13: sum and difference
        for (int byt = 0; byt < 2; byt++) begin
            tag = byt ? "R13" : "R12";
            configure(K_SD, 0, 0, byt[0], 0, 16'h0000, 0);
            foreach (vals[i]) foreach (vals[j]) step(1, vals[i], 1, vals[j], 0, 0);
        end

        // R14: pass and constant
        tag = "R14";
        configure(K_PASS, 0, 0, 0, 0, 16'h0000, 0);
        foreach (vals[i]) step(1, vals[i], 0, 16'h0000, 0, 0);
        configure(K_PASS, 0, 0, 1, 0, 16'h0000, 0);
        step(1, 16'hABCD, 0, 16'h0000, 0, 0);
        configure(K_CONST, 0, 0, 0, 0, 16'hBEEF, 0);
        step(1, 16'h0000, 0, 16'h0000, 0, 0);
        step(0, 16'h0000, 1, 16'h0000, 0, 0);
        configure(K_CONST, 0, 0, 1, 0, 16'hBEEF, 0);
        step(1, 16'h0000, 0, 16'h0000, 0, 0);

        step(0, 16'h0000, 0, 16'h0000, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule